// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block sits beside an integer datapath and runs the long-latency multiply and divide operations away from the main ALU. A start command carries an operation code and two 32-bit operands. The command names no destination register. The 64-bit result lands in a dedicated register pair: HI holds the upper word of a product or the remainder of a division, and LO holds the lower word of a product or the quotient. The datapath keeps issuing other work while the unit iterates. It collects the result later with a move-from read, and it can preload either register with a move-to write.

Both operations are computed on operand magnitudes, one bit per cycle. A shift-add multiplier handles products and a restoring divider handles quotients. A final correction cycle applies signs and commits the pair. The controller has four states. IDLE accepts commands, writes and reads. MUL and DIV each run W iterations. FIX applies the signs and writes HI and LO. The transitions are:
- IDLE to MUL when a multiply command is accepted.
- IDLE to DIV when a divide command is accepted.
- MUL to FIX and DIV to FIX after the last iteration.
- FIX to IDLE unconditionally.

`busy` is high in every state except IDLE. A read that arrives while `busy` is high is parked and answered once the new result is in place. None of the operations signals overflow.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO read as zero and `busy` and `rd_valid` are low.
- R2: Operation code 2'b01 (unsigned multiply) leaves the upper 32 bits of the unsigned 64-bit product in HI and the lower 32 bits in LO.
- R3: Operation code 2'b00 (signed multiply) leaves the two's-complement 64-bit product in HI (upper) and LO (lower), including the case of both operands equal to -2^31.
- R4: Operation code 2'b11 (unsigned divide) leaves the quotient in LO and the remainder in HI.
- R5: Operation code 2'b10 (signed divide) truncates the quotient toward zero, and the remainder takes the sign of the dividend. -2^31 divided by -1 gives LO = 32'h8000_0000 and HI = 0.
- R6: A divide by zero completes in the normal time. In unsigned form it gives LO = all ones and HI = the dividend.
- R7: A command is accepted only in IDLE. `busy` rises after the accepting clock edge and stays high for exactly W+1 = 33 cycles, then the unit returns to IDLE.
- R8: In IDLE with no command present, `wr_hi`/`wr_lo` load HI/LO from `wr_data`. A read (`rd_req`, with `rd_sel` 1 = HI and 0 = LO) returns the value one cycle later with `rd_valid` high for one cycle.
- R9: A read requested while `busy` is high is held. It is answered one cycle after `busy` falls, with the newly computed value.
- R10: Commands and move-to writes presented while `busy` is high are ignored. The running result and its duration are unchanged.
- R11: A read and a write to the same register in the same idle cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a multiply or divide |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Move-to-HI strobe |
| wr_lo | input | 1 | Move-to-LO strobe |
| wr_data | input | 32 | Data for move-to writes |
| rd_req | input | 1 | Move-from request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 32 | Read data |
| busy | output | 1 | Operation in progress |

## Verification
The assertions assume that `rd_sel`, `wr_data` and the operands are stable whenever their strobes are high. They also assume that at most one read is outstanding while the unit is busy, so a parked read is never overwritten before it is served. The stimulus changes inputs only on falling edges and holds them for whole cycles. It issues a single read during each busy window. Commands and writes that overlap a running operation are deliberate and exist only to exercise R10.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_FIX
    } md_state_e;
endpackage

// File: rtl/md_mul_iter.sv
module md_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);
    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] acc_q;
    logic [W:0]     sum;
    logic [2*W-1:0] acc_nxt;

    // add the multiplicand into the upper half when the current low bit is set
    always_comb begin
        sum     = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
        acc_nxt = {sum, acc_q[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc_q   <= acc_nxt;
        end
    end

    assign prod = acc_q;

    // the multiplicand must not move while iterations are under way
    p_mcand_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(mcand_q));
endmodule

// File: rtl/md_div_iter.sv
module md_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dvs_q;
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         borrow;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs_q};
        borrow  = diff[W+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend_in;
            dvs_q <= divisor_in;
        end else if (step) begin
            if (borrow) begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end else begin
                rem_q <= diff[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end
        end
    end

    assign quo = quo_q;
    assign rem = rem_q;

    // restoring invariant: partial remainder stays below a nonzero divisor
    p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/md_sign_fix.sv
module md_sign_fix #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic           signed_op,
    input  logic           a_neg,
    input  logic           b_neg,
    input  logic [2*W-1:0] mag_prod,
    input  logic [W-1:0]   mag_quo,
    input  logic [W-1:0]   mag_rem,
    output logic [W-1:0]   hi_out,
    output logic [W-1:0]   lo_out
);
    logic           flip_res;
    logic           flip_rem;
    logic [2*W-1:0] prod_fix;

    always_comb begin
        flip_res = signed_op && (a_neg ^ b_neg);
        flip_rem = signed_op && a_neg;
        prod_fix = flip_res ? (~mag_prod + 1'b1) : mag_prod;
        if (is_div) begin
            lo_out = flip_res ? (~mag_quo + 1'b1) : mag_quo;
            hi_out = flip_rem ? (~mag_rem + 1'b1) : mag_rem;
        end else begin
            lo_out = prod_fix[W-1:0];
            hi_out = prod_fix[2*W-1:W];
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    input  logic         rd_sel,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         busy
);
    localparam int CNT_W = $clog2(W);
    localparam int RUN_W = CNT_W + 2;

    md_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic           signed_q, div_q, an_q, bn_q;
    logic [W-1:0]   hi_q, lo_q;
    logic           pend_q, pend_sel_q;
    logic           rd_valid_q;
    logic [W-1:0]   rd_data_q;

    logic           accept, last_iter, in_sgn, in_an, in_bn;
    logic [W-1:0]   mag_a, mag_b;
    logic [2*W-1:0] mul_prod;
    logic [W-1:0]   div_quo, div_rem, fix_hi, fix_lo;

    always_comb begin
        accept    = (state_q == ST_IDLE) && cmd_valid;
        last_iter = (cnt_q == CNT_W'(W-1));
        in_sgn    = !cmd_op[0];
        in_an     = in_sgn && opa[W-1];
        in_bn     = in_sgn && opb[W-1];
        mag_a     = in_an ? (~opa + 1'b1) : opa;
        mag_b     = in_bn ? (~opb + 1'b1) : opb;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = cmd_op[1] ? ST_DIV : ST_MUL;
            ST_MUL:  if (last_iter) state_d = ST_FIX;
            ST_DIV:  if (last_iter) state_d = ST_FIX;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    md_mul_iter #(.W(W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && !cmd_op[1]),
        .step      (state_q == ST_MUL),
        .mcand_in  (mag_a),
        .mplier_in (mag_b),
        .prod      (mul_prod)
    );

    md_div_iter #(.W(W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && cmd_op[1]),
        .step        (state_q == ST_DIV),
        .dividend_in (mag_a),
        .divisor_in  (mag_b),
        .quo         (div_quo),
        .rem         (div_rem)
    );

    md_sign_fix #(.W(W)) u_fix (
        .is_div    (div_q),
        .signed_op (signed_q),
        .a_neg     (an_q),
        .b_neg     (bn_q),
        .mag_prod  (mul_prod),
        .mag_quo   (div_quo),
        .mag_rem   (div_rem),
        .hi_out    (fix_hi),
        .lo_out    (fix_lo)
    );

    // outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            signed_q   <= 1'b0;
            div_q      <= 1'b0;
            an_q       <= 1'b0;
            bn_q       <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
            pend_q     <= 1'b0;
            pend_sel_q <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cnt_q    <= '0;
                        signed_q <= in_sgn;
                        div_q    <= cmd_op[1];
                        an_q     <= in_an;
                        bn_q     <= in_bn;
                    end else begin
                        if (wr_hi) hi_q <= wr_data;
                        if (wr_lo) lo_q <= wr_data;
                    end
                    if (pend_q) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= pend_sel_q ? hi_q : lo_q;
                        pend_q     <= rd_req;
                        pend_sel_q <= rd_sel;
                    end else if (rd_req) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= rd_sel ? hi_q : lo_q;
                    end
                end
                ST_MUL, ST_DIV: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (rd_req) begin
                        pend_q     <= 1'b1;
                        pend_sel_q <= rd_sel;
                    end
                end
                ST_FIX: begin
                    hi_q <= fix_hi;
                    lo_q <= fix_lo;
                    if (rd_req) begin
                        pend_q     <= 1'b1;
                        pend_sel_q <= rd_sel;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // checker: length of a busy run, watched with a counter
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run_q <= '0;
        else if (busy) busy_run_q <= busy_run_q + 1'b1;
        else           busy_run_q <= '0;
    end

    p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_W'(W+1));

    p_fix_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |=> (state_q == ST_IDLE));

    p_read_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state_q == ST_IDLE));

    p_busy_drops_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MUL || state_q == ST_DIV) && (wr_hi || wr_lo))
        |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/test_muldiv_hilo.sv
module test_muldiv_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] opa = '0, opb = '0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0, rd_sel = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    muldiv_hilo i_muldiv_hilo (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .opa(opa), .opb(opb), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .rd_req(rd_req), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          output int cycles);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; opa = a; opb = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        cycles = 0;
        while (busy && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] data);
        int guard;
        @(negedge clk);
        rd_req = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_req = 1'b0;
        guard = 0;
        while (!rd_valid && guard < 1000) begin
            guard++;
            @(negedge clk);
        end
        data = rd_valid ? rd_data : 32'hxxxx_xxxx;
    endtask

    task automatic op_and_check(input string req, input logic [1:0] op,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] ehi, input logic [31:0] elo);
        int cyc;
        logic [31:0] h, l;
        run_op(op, a, b, cyc);
        rd(1'b1, h);
        rd(1'b0, l);
        chk(req, {h, l}, {ehi, elo});
        chk("R7 busy length", 64'(cyc), 64'd33);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        rd(1'b1, v); chk("R1 HI", 64'(v), 64'd0);
        rd(1'b0, v); chk("R1 LO", 64'(v), 64'd0);
    endtask

    task automatic t_mul_u;
        logic [31:0] a[3] = '{32'd3, 32'hFFFF_FFFF, 32'h1234_5678};
        logic [31:0] b[3] = '{32'd5, 32'hFFFF_FFFF, 32'h9ABC_DEF0};
        for (int i = 0; i < 3; i++) begin
            logic [63:0] e;
            e = 64'(a[i]) * 64'(b[i]);
            op_and_check("R2 unsigned mul", 2'b01, a[i], b[i], e[63:32], e[31:0]);
        end
    endtask

    task automatic t_mul_s;
        logic [31:0] a[4] = '{32'hFFFF_FFFD, 32'h8000_0000, 32'd7, 32'hFFFF_FFFF};
        logic [31:0] b[4] = '{32'd5, 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
        for (int i = 0; i < 4; i++) begin
            longint e;
            e = longint'($signed(a[i])) * longint'($signed(b[i]));
            op_and_check("R3 signed mul", 2'b00, a[i], b[i], e[63:32], e[31:0]);
        end
    endtask

    task automatic t_div_u;
        logic [31:0] a[3] = '{32'd100, 32'hFFFF_FFFF, 32'd5};
        logic [31:0] b[3] = '{32'd7, 32'd10, 32'd9};
        for (int i = 0; i < 3; i++)
            op_and_check("R4 unsigned div", 2'b11, a[i], b[i], a[i] % b[i], a[i] / b[i]);
    endtask

    task automatic t_div_s;
        logic [31:0] a[3] = '{32'hFFFF_FFF9, 32'd7, 32'hFFFF_FFF9};
        logic [31:0] b[3] = '{32'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFE};
        for (int i = 0; i < 3; i++) begin
            int q, r;
            q = $signed(a[i]) / $signed(b[i]);
            r = $signed(a[i]) % $signed(b[i]);
            op_and_check("R5 signed div", 2'b10, a[i], b[i], 32'(r), 32'(q));
        end
        op_and_check("R5 signed div min/-1", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF,
                     32'h0, 32'h8000_0000);
    endtask

    task automatic t_div_zero;
        int cyc;
        op_and_check("R6 unsigned div by zero", 2'b11, 32'd1234, 32'd0, 32'd1234, 32'hFFFF_FFFF);
        run_op(2'b10, 32'hFFFF_FF00, 32'd0, cyc);
        chk("R6 signed div by zero completes", 64'(cyc), 64'd33);
    endtask

    task automatic t_move;
        logic [31:0] v;
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'hA5A5_0F0F;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 32'h1357_9BDF;
        @(negedge clk);
        wr_lo = 1'b0;
        rd(1'b1, v); chk("R8 move-to HI", 64'(v), 64'hA5A5_0F0F);
        rd(1'b0, v); chk("R8 move-to LO", 64'(v), 64'h1357_9BDF);
        // R11: read and write of LO in the same idle cycle
        @(negedge clk);
        rd_req = 1'b1; rd_sel = 1'b0; wr_lo = 1'b1; wr_data = 32'h0BAD_CAFE;
        @(negedge clk);
        rd_req = 1'b0; wr_lo = 1'b0;
        chk("R11 rd_valid", 64'(rd_valid), 64'd1);
        chk("R11 old value", 64'(rd_data), 64'h1357_9BDF);
        rd(1'b0, v); chk("R11 write landed", 64'(v), 64'h0BAD_CAFE);
    endtask

    task automatic t_busy_ignore;
        int cyc;
        logic [31:0] h, l;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; opa = 32'd6; opb = 32'd7;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; opa = 32'd1; opb = 32'd1;
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
        cyc = 0;
        for (int k = 0; k < 3; k++) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        chk("R10 duration unchanged", 64'(cyc), 64'd33);
        rd(1'b1, h);
        rd(1'b0, l);
        chk("R10 result unchanged", {h, l}, 64'd42);
    endtask

    task automatic t_pending;
        int guard;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11; opa = 32'd100; opb = 32'd7;
        @(negedge clk);
        cmd_valid = 1'b0;
        rd_req = 1'b1; rd_sel = 1'b0;
        @(negedge clk);
        rd_req = 1'b0;
        guard = 0;
        while (!rd_valid && guard < 1000) begin
            chk("R9 no early data", 64'(rd_valid), 64'd0);
            guard++;
            @(negedge clk);
        end
        chk("R9 held read data", 64'(rd_data), 64'd14);
        chk("R9 served after busy", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R9 single pulse", 64'(rd_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mul_u();
        t_mul_s();
        t_div_u();
        t_div_s();
        t_div_zero();
        t_move();
        t_busy_ignore();
        t_pending();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule